// File: doc/BRIEF.md
# Coprocessor Memory Window Mapper

This block turns the 16-bit address of a sound coprocessor CPU into a physical memory access. It selects ROM or RAM and produces a 23-bit physical address, which is a page number joined to the offset within the page. The lower half of the CPU space is fixed. The upper half is a paged window. A configuration register chooses how that window is split, whether ROM is visible at all, and whether the first 32 KB of RAM is shielded from writes. The same register also carries a clock-select field and two channel-mode flags, which leave the block as plain outputs for the neighbouring clock and mixer logic.

Software writes the configuration register and two 8-bit page registers through a shared write-data bus with one strobe per register. Every register write takes effect on the clock edge that samples it. The address decode is combinational on the registered state, so a memory request is mapped in the same cycle it is presented.

The window layout is held as a two-state mode register. The states are WIN_ONE_BIG (one 32 KB window at 0x8000–0xFFFF, named by the main page register) and WIN_TWO_SMALL (two 16 KB windows, the main page register at 0x8000–0xBFFF and the extended page register at 0xC000–0xFFFF). There are two transitions, and both happen on a configuration write. GO_SPLIT moves from WIN_ONE_BIG to WIN_TWO_SMALL when the written value has bit 3 set. GO_JOIN moves back when bit 3 is clear. Reset enters WIN_ONE_BIG.

Top module: `memwin_mapper`

## Requirements
- R1: After reset, the configuration register and both page registers read as zero, the mode is WIN_ONE_BIG and the side outputs are all zero.
- R2: `cfg_rdata` returns the last value written with `cfg_we`, starting in the cycle after the write edge.
- R3: For CPU addresses 0x0000–0x3FFF the physical address is the 14-bit offset with all page bits zero. The device is ROM when config bit 0 is 0 and RAM when config bit 0 is 1.
- R4: For CPU addresses 0x4000–0x7FFF the device is always RAM. The physical address is 0x4000 plus the offset (small page 1), whatever the page registers and mode hold.
- R5: With config bit 3 = 0, addresses 0x8000–0xFFFF map to physical `{main_page, addr[14:0]}` (32 KB pages) and the extended page register has no effect. Config bit 0 selects ROM (0) or RAM (1) for the window.
- R6: With config bit 3 = 1, 0x8000–0xBFFF maps to `{0, main_page, addr[13:0]}` and 0xC000–0xFFFF maps to `{0, ext_page, addr[13:0]}` (16 KB pages). A big page therefore equals the small page number shifted right by one. The device is chosen by config bit 0, as in R5.
- R7: `rom_cs` and `ram_cs` are never both high, and both are low whenever `mem_req` is low.
- R8: `ram_we` is high exactly when `mem_req`, `mem_wr` and `ram_cs` are high, unless config bit 1 is 1 and the physical address is below 0x8000 (big page 0).
- R9: `clk_sel` equals config bits 5:4 (00 = 24 MHz, 01 = 12 MHz, 10 = 20 MHz, 11 = 10 MHz). `chan8_en` equals config bit 2 and `pan4_en` equals config bit 6.
- R10: A page register keeps its value unless its own strobe is high, and a new page value steers the mapping from the cycle after its write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_addr | input | 16 | CPU address |
| mem_req | input | 1 | Memory request |
| mem_wr | input | 1 | Memory write strobe |
| reg_wdata | input | 8 | Write data for the configuration and page registers |
| cfg_we | input | 1 | Write strobe for the configuration register |
| page_main_we | input | 1 | Write strobe for the main page register |
| page_ext_we | input | 1 | Write strobe for the extended page register |
| cfg_rdata | output | 8 | Configuration register read-back |
| rom_cs | output | 1 | ROM chip select |
| ram_cs | output | 1 | RAM chip select |
| phys_addr | output | 23 | Physical address (page number and offset) |
| ram_we | output | 1 | RAM write enable after the write-protection gate |
| clk_sel | output | 2 | Clock-select field |
| chan8_en | output | 1 | Eight-channel mode flag |
| pan4_en | output | 1 | Four-channel panning mode flag |

## Verification
A wrong mode state or a stale page register has no effect at the ports until the CPU touches 0x8000–0xFFFF. It then shows up at once as a wrong page in `phys_addr`, or, for a mode error, as the wrong register steering the 0xC000 half. For that reason the reference model is compared on every cycle against an address stream that keeps returning to both halves of the window. A corrupted protect or ROM-off bit shows up in the same cycle as a request to the fixed region. It appears as a missing `ram_we` or a swapped chip select. The read-back port shows any configuration error one cycle after the write that should have set it.

// File: rtl/memwin_pkg.sv
package memwin_pkg;
    localparam int CPU_AW     = 16;
    localparam int SMALL_OFFW = 14;
    localparam int BIG_OFFW   = SMALL_OFFW + 1;
    localparam int PAGE_W     = 8;
    localparam int CFG_W      = 8;
    localparam int PHYS_W     = PAGE_W + BIG_OFFW;
    localparam int NUM_PAGES  = 2;

    localparam int CFG_NOROM  = 0;
    localparam int CFG_RAMRO  = 1;
    localparam int CFG_CH8    = 2;
    localparam int CFG_SPLIT  = 3;
    localparam int CFG_CLK_LO = 4;
    localparam int CFG_CLK_HI = 5;
    localparam int CFG_PAN4   = 6;

    localparam int PG_MAIN = 0;
    localparam int PG_EXT  = 1;

    typedef enum logic {
        WIN_ONE_BIG   = 1'b0,
        WIN_TWO_SMALL = 1'b1
    } win_mode_e;

    typedef enum logic [1:0] {
        RGN_FIXED_ROM = 2'b00,
        RGN_FIXED_RAM = 2'b01,
        RGN_WIN_LO    = 2'b10,
        RGN_WIN_HI    = 2'b11
    } region_e;
endpackage

// File: rtl/memwin_regs.sv
module memwin_regs
    import memwin_pkg::*;
#(
    parameter int P_W = PAGE_W,
    parameter int C_W = CFG_W,
    parameter int NP  = NUM_PAGES
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [C_W-1:0] wdata,
    input  logic           cfg_we,
    input  logic [NP-1:0]  page_we,
    output logic [C_W-1:0] cfg_q,
    output logic [P_W-1:0] page_q [NP],
    output win_mode_e      mode_q
);
    win_mode_e mode_d;

    // configuration register
    always_ff @(posedge clk) begin
        if (!rst_n)      cfg_q <= '0;
        else if (cfg_we) cfg_q <= wdata;
    end

    // page registers, one per window
    for (genvar g = 0; g < NP; g++) begin : g_page
        always_ff @(posedge clk) begin
            if (!rst_n)          page_q[g] <= '0;
            else if (page_we[g]) page_q[g] <= wdata[P_W-1:0];
        end

        // R10: a page holds unless its own strobe was high
        a_r10_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(page_we[g]) |-> $stable(page_q[g]));
    end

    // window mode state register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= WIN_ONE_BIG;
        else        mode_q <= mode_d;
    end

    // mode transitions: GO_SPLIT and GO_JOIN
    always_comb begin
        mode_d = mode_q;
        unique case (mode_q)
            WIN_ONE_BIG:   if (cfg_we && wdata[CFG_SPLIT])  mode_d = WIN_TWO_SMALL;
            WIN_TWO_SMALL: if (cfg_we && !wdata[CFG_SPLIT]) mode_d = WIN_ONE_BIG;
            default:       mode_d = WIN_ONE_BIG;
        endcase
    end

    // R2: read-back follows the last write
    a_r2_readback: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> cfg_q == $past(wdata));

    // R6: the mode state agrees with the layout bit
    a_r6_mode_track: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == WIN_TWO_SMALL) == cfg_q[CFG_SPLIT]);
endmodule

// File: rtl/memwin_decode.sv
module memwin_decode
    import memwin_pkg::*;
#(
    parameter int P_W = PAGE_W,
    parameter int NP  = NUM_PAGES,
    localparam int PW = P_W + BIG_OFFW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] addr,
    input  logic              req,
    input  logic              rom_off,
    input  win_mode_e         mode,
    input  logic [P_W-1:0]    page_q [NP],
    output logic              rom_cs,
    output logic              ram_cs,
    output logic [PW-1:0]     phys
);
    region_e                rgn;
    logic                   hit_rom;
    logic [SMALL_OFFW-1:0]  off_s;
    logic [BIG_OFFW-1:0]    off_b;

    assign rgn   = region_e'(addr[CPU_AW-1 -: 2]);
    assign off_s = addr[SMALL_OFFW-1:0];
    assign off_b = addr[BIG_OFFW-1:0];

    always_comb begin
        hit_rom = 1'b0;
        phys    = '0;
        unique case (rgn)
            RGN_FIXED_ROM: begin
                hit_rom = !rom_off;
                phys    = PW'(off_s);
            end
            RGN_FIXED_RAM: begin
                hit_rom = 1'b0;
                phys    = PW'({1'b1, off_s});
            end
            RGN_WIN_LO, RGN_WIN_HI: begin
                hit_rom = !rom_off;
                if (mode == WIN_ONE_BIG)
                    phys = {page_q[PG_MAIN], off_b};
                else if (rgn == RGN_WIN_LO)
                    phys = PW'({page_q[PG_MAIN], off_s});
                else
                    phys = PW'({page_q[PG_EXT], off_s});
            end
            default: begin
                hit_rom = 1'b0;
                phys    = '0;
            end
        endcase
    end

    assign rom_cs = req &&  hit_rom;
    assign ram_cs = req && !hit_rom;

    // R7: selects are exclusive and idle without a request
    a_r7_cs_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(rom_cs && ram_cs));
    a_r7_cs_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !rom_cs && !ram_cs);
    // R4: the fixed RAM quarter is small page 1 on RAM
    a_r4_fixed_ram: assert property (@(posedge clk) disable iff (!rst_n)
        req && addr[CPU_AW-1 -: 2] == 2'b01 |-> ram_cs && phys[PW-1:SMALL_OFFW] == 1);
endmodule

// File: rtl/memwin_wprot.sv
module memwin_wprot
    import memwin_pkg::*;
#(
    parameter int PW = PHYS_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req,
    input  logic          wr,
    input  logic          ram_cs,
    input  logic          ro_en,
    input  logic [PW-1:0] phys,
    output logic          ram_we
);
    logic in_page0;

    assign in_page0 = (phys[PW-1:BIG_OFFW] == '0);
    assign ram_we   = req && wr && ram_cs && !(ro_en && in_page0);

    // R8: a protected page never sees a write strobe
    a_r8_protect: assert property (@(posedge clk) disable iff (!rst_n)
        ro_en && phys < PW'(1 << BIG_OFFW) |-> !ram_we);
    a_r8_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> wr && ram_cs);
endmodule

// File: rtl/memwin_mapper.sv
module memwin_mapper
    import memwin_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              mem_req,
    input  logic              mem_wr,
    input  logic [CFG_W-1:0]  reg_wdata,
    input  logic              cfg_we,
    input  logic              page_main_we,
    input  logic              page_ext_we,
    output logic [CFG_W-1:0]  cfg_rdata,
    output logic              rom_cs,
    output logic              ram_cs,
    output logic [PHYS_W-1:0] phys_addr,
    output logic              ram_we,
    output logic [1:0]        clk_sel,
    output logic              chan8_en,
    output logic              pan4_en
);
    logic [CFG_W-1:0]     cfg_q;
    logic [PAGE_W-1:0]    page_q [NUM_PAGES];
    logic [NUM_PAGES-1:0] page_we;
    win_mode_e            mode_q;

    assign page_we[PG_MAIN] = page_main_we;
    assign page_we[PG_EXT]  = page_ext_we;

    memwin_regs #(.P_W(PAGE_W), .C_W(CFG_W), .NP(NUM_PAGES)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wdata   (reg_wdata),
        .cfg_we  (cfg_we),
        .page_we (page_we),
        .cfg_q   (cfg_q),
        .page_q  (page_q),
        .mode_q  (mode_q)
    );

    memwin_decode #(.P_W(PAGE_W), .NP(NUM_PAGES)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .addr    (cpu_addr),
        .req     (mem_req),
        .rom_off (cfg_q[CFG_NOROM]),
        .mode    (mode_q),
        .page_q  (page_q),
        .rom_cs  (rom_cs),
        .ram_cs  (ram_cs),
        .phys    (phys_addr)
    );

    memwin_wprot #(.PW(PHYS_W)) u_wp (
        .clk    (clk),
        .rst_n  (rst_n),
        .req    (mem_req),
        .wr     (mem_wr),
        .ram_cs (ram_cs),
        .ro_en  (cfg_q[CFG_RAMRO]),
        .phys   (phys_addr),
        .ram_we (ram_we)
    );

    assign cfg_rdata = cfg_q;
    assign clk_sel   = cfg_q[CFG_CLK_HI:CFG_CLK_LO];
    assign chan8_en  = cfg_q[CFG_CH8];
    assign pan4_en   = cfg_q[CFG_PAN4];

    // R9: side outputs follow the value written last
    a_r9_side_out: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cfg_we) |-> clk_sel == $past(reg_wdata[5:4]) && pan4_en == $past(reg_wdata[6]));
endmodule

// File: tb/memwin_mapper_tb.sv
module memwin_mapper_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [15:0] cpu_addr = 0;
    logic        mem_req = 0, mem_wr = 0;
    logic [7:0]  reg_wdata = 0;
    logic        cfg_we = 0, page_main_we = 0, page_ext_we = 0;
    logic [7:0]  cfg_rdata;
    logic        rom_cs, ram_cs, ram_we, chan8_en, pan4_en;
    logic [22:0] phys_addr;
    logic [1:0]  clk_sel;

    int n_run = 0, n_fail = 0;
    int m_cfg = 0, m_pm = 0, m_pe = 0;

    always #10 clk = ~clk;

    memwin_mapper u_dut (.*);

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference, compared every cycle
    task automatic compare();
        int a, rgn, ephys, erom, eram, ewe;
        string tag;
        a = cpu_addr; rgn = a / 16384;
        if (rgn == 0)      begin ephys = a % 16384;          tag = "R3"; end
        else if (rgn == 1) begin ephys = 16384 + a % 16384;  tag = "R4"; end
        else if ((m_cfg & 8) == 0) begin ephys = m_pm * 32768 + a % 32768; tag = "R5"; end
        else begin ephys = ((rgn == 2) ? m_pm : m_pe) * 16384 + a % 16384; tag = "R6"; end
        erom = (rgn != 1 && (m_cfg & 1) == 0) ? 1 : 0;
        eram = 1 - erom;
        if (!mem_req) begin erom = 0; eram = 0; tag = "R7"; end
        ewe = (mem_req && mem_wr && eram && !((m_cfg & 2) != 0 && ephys < 32768)) ? 1 : 0;
        chk(tag, "rom_cs", rom_cs, erom);
        chk(tag, "ram_cs", ram_cs, eram);
        if (mem_req) chk(tag, "phys_addr", phys_addr, ephys);
        chk("R8", "ram_we", ram_we, ewe);
        chk("R2", "cfg_rdata", cfg_rdata, m_cfg);
        chk("R9", "clk_sel", clk_sel, (m_cfg >> 4) & 3);
        chk("R9", "chan8_en", chan8_en, (m_cfg >> 2) & 1);
        chk("R9", "pan4_en", pan4_en, (m_cfg >> 6) & 1);
    endtask

    // one cycle: drive at negedge, compare, then let the model follow the edge
    task automatic cyc(input int a, input bit rq, input bit wr, input int wd,
                       input bit cw, input bit pmw, input bit pew);
        @(negedge clk);
        cpu_addr = 16'(a); mem_req = rq; mem_wr = wr; reg_wdata = 8'(wd);
        cfg_we = cw; page_main_we = pmw; page_ext_we = pew;
        #3;
        compare();
        if (cw)  m_cfg = wd & 255;
        if (pmw) m_pm  = wd & 255;
        if (pew) m_pe  = wd & 255;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "cfg_rdata", cfg_rdata, 0);
        chk("R1", "clk_sel", clk_sel, 0);
        chk("R1", "pan4_en", pan4_en, 0);
        rst_n = 1;
        cyc('hC123, 1, 0, 0, 0, 0, 0);
        chk("R1", "phys_addr", phys_addr, 'h4123);
        // R10: new page steers mapping from the next cycle
        cyc('h8000, 1, 0, 'h5A, 0, 1, 0);
        cyc('h8004, 1, 0, 0, 0, 0, 0);
        chk("R10", "phys_addr", phys_addr, 'h5A * 32768 + 4);
        // R5: extended page ignored in big mode
        cyc('hC000, 1, 0, 'h33, 0, 0, 1);
        cyc('hC010, 1, 0, 0, 0, 0, 0);
        chk("R5", "phys_addr", phys_addr, 'h5A * 32768 + 'h4010);
        // R6: GO_SPLIT then GO_JOIN
        cyc(0, 0, 0, 'h08, 1, 0, 0);
        cyc('hC010, 1, 0, 0, 0, 0, 0);
        chk("R6", "phys_addr", phys_addr, 'h33 * 16384 + 'h10);
        cyc(0, 0, 0, 'h01, 1, 0, 0);
        cyc('hC010, 1, 1, 0, 0, 0, 0);
        chk("R6", "ram_cs", ram_cs, 1);
        // R8: protect page 0, RAM everywhere
        cyc(0, 0, 0, 'h03, 1, 0, 0);
        cyc('h4100, 1, 1, 0, 0, 0, 0);
        chk("R8", "ram_we", ram_we, 0);
        cyc('h0100, 1, 1, 0, 0, 0, 0);
        chk("R3", "ram_cs", ram_cs, 1);
        // R9: clock field value 10
        cyc(0, 0, 0, 'h64, 1, 0, 0);
        cyc(0, 0, 0, 0, 0, 0, 0);
        chk("R9", "clk_sel", clk_sel, 2);
        // random traffic
        for (int i = 0; i < 4000; i++) begin
            int sel;
            sel = $urandom % 16;
            cyc($urandom % 65536, ($urandom % 4) != 0, $urandom % 2, $urandom % 256,
                sel == 0, sel == 1 || sel == 3, sel == 2 || sel == 3);
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #2000000;
        n_fail++; n_run++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule